// File: doc/BRIEF.md
# I2C Bus Hang Recovery Controller

This block sits beside an I2C master and watches the shared clock and data wires. Each wire passes through a two-flop synchronizer. A low-time counter then flags a wire that has been held low for longer than a programmed number of system clocks. On a recover command, the block handles the two kinds of hang differently. A clock wire held low cannot be freed from the master side, so the block only reports it. A data wire held low is freed by toggling the clock wire a bounded number of times until the data wire reads high. The block then places a START and a STOP on the bus, so that every slave that lost its place in a frame starts again from a clean state.

The block also follows ordinary bus traffic. It counts clock rises from each START and raises a one-cycle error pulse when a START or STOP shows up inside a byte or its acknowledge bit. Both wires are driven in open-drain fashion, so a drive output only ever pulls a wire low. Recovery states are `S_IDLE`, `S_PULSE_LO`, `S_PULSE_HI`, `S_START_PREP`, `S_START_HOLD`, `S_STOP_LO` and `S_STOP_HI`. They move as follows:

- `S_IDLE` goes to `S_PULSE_LO` when data is low at the command, or to `S_START_PREP` when data is high.
- `S_PULSE_LO` goes to `S_PULSE_HI`.
- `S_PULSE_HI` goes to `S_START_PREP` when data reads high. It returns to `S_PULSE_LO` while pulses remain, and goes to `S_IDLE` with a failure status when they are used up.
- `S_START_PREP` goes to `S_START_HOLD`, then `S_STOP_LO`, then `S_STOP_HI`, then back to `S_IDLE`.

Top module: `bus_unjam_ctrl`

## Requirements
- R1: `scl_stuck` / `sda_stuck` rise once the synchronized wire has been low for `timeout_lim` consecutive system clocks (a 20-clock limit flags within 30 clocks of the wire falling and not within 15). They drop when the wire reads high and are held low while `busy` is high.
- R2: A recover command while the synchronized clock wire is low sets `status` to 0xE8. In that case `busy` stays low and neither wire is driven.
- R3: A recover command with the clock wire high and the data wire low starts clock pulses. Each pulse is a driven-low phase and a released phase of `phase_len` clocks each. Data is sampled at the end of each released phase, and pulsing stops at the first pulse that sees it high, after at most 9 pulses. When data is already high at the command, no pulse is sent.
- R4: If data is still low at the end of the ninth pulse, `status` becomes 0xE0 and the block returns to idle with no START and no further clock rise.
- R5: A START is only driven once both wires have read high for `phase_len` consecutive clocks. If data drops during that wait, the wait starts over.
- R6: After data is free, the block drives exactly one START (data low while clock high) and one STOP (data released while clock high), sets `status` to 0x08 and leaves both wires released.
- R7: While `busy` is low both drive outputs are low. A recover command during recovery has no effect on the pulse count or on the sequence.
- R8: After a bus START, `bus_err` pulses for one clock when a START or STOP is seen at a clock-rise count other than 0 or "first rise after a completed 9-rise byte". A 9-rise byte followed by a STOP gives no error.
- R9: `bus_err` stays low during recovery and for bus activity the block itself generates.
- R10: After reset, `status` is 0xF8, `busy` and `bus_err` are low and neither wire is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Level of the bus clock wire |
| sda_in | input | 1 | Level of the bus data wire |
| recover | input | 1 | One-clock command to start hang recovery |
| timeout_lim | input | TMO_W | Low-time limit in system clocks |
| phase_len | input | PH_W | Length of each pulse phase in system clocks |
| scl_drive_low | output | 1 | Pull the clock wire low |
| sda_drive_low | output | 1 | Pull the data wire low |
| busy | output | 1 | Recovery in progress |
| scl_stuck | output | 1 | Clock wire low past the limit |
| sda_stuck | output | 1 | Data wire low past the limit |
| status | output | 8 | Outcome code of the last recover command |
| bus_err | output | 1 | One-clock pulse on a misplaced START or STOP |

## Verification
Recovery is tried with a slave model that lets go of the data wire after 0, 3, 9 and 10 falling clock edges. These cases separate the no-pulse path, an early release, release on the last allowed pulse, and the failure case. A separate run pulls data low again during the START wait; it shows that the START is held back and then retried rather than issued blindly. Bus traffic driven by the bench compares a clean 9-bit byte with a STOP, a STOP after three bits, and a repeated START after two bits. This tells legal frame boundaries apart from misplaced conditions.

// File: rtl/unjam_pkg.sv
package unjam_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PULSE_LO,
        S_PULSE_HI,
        S_START_PREP,
        S_START_HOLD,
        S_STOP_LO,
        S_STOP_HI
    } rec_state_t;

    localparam logic [7:0] ST_NONE      = 8'hF8;
    localparam logic [7:0] ST_RESYNC_OK = 8'h08;
    localparam logic [7:0] ST_SDA_FAIL  = 8'hE0;
    localparam logic [7:0] ST_SCL_STUCK = 8'hE8;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '1;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stuck_timer.sv
module stuck_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          line_s,
    input  logic [CW-1:0] limit,
    output logic          stuck
);
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (clear || line_s)
            low_cnt <= '0;
        else if (low_cnt < limit)
            low_cnt <= low_cnt + 1'b1;
    end

    assign stuck = !clear && !line_s && (low_cnt >= limit);
endmodule

// File: rtl/cond_detect.sv
module cond_detect #(
    parameter int FRAME_RISES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    input  logic mute,
    output logic bus_err
);
    localparam int CNT_W    = $clog2(FRAME_RISES + 2);
    localparam int NEXT_ONE = FRAME_RISES + 1;

    logic             scl_p, sda_p, in_frame;
    logic [CNT_W-1:0] rise_cnt;
    logic             start_c, stop_c, scl_rise, at_boundary;

    assign start_c     = scl_s && scl_p && sda_p && !sda_s;
    assign stop_c      = scl_s && scl_p && !sda_p && sda_s;
    assign scl_rise    = scl_s && !scl_p;
    assign at_boundary = (rise_cnt == '0) || (rise_cnt == CNT_W'(NEXT_ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            in_frame <= 1'b0;
            rise_cnt <= '0;
            bus_err  <= 1'b0;
        end else begin
            scl_p   <= scl_s;
            sda_p   <= sda_s;
            bus_err <= 1'b0;
            if (mute) begin
                in_frame <= 1'b0;
                rise_cnt <= '0;
            end else if (start_c) begin
                bus_err  <= in_frame && !at_boundary;
                in_frame <= 1'b1;
                rise_cnt <= '0;
            end else if (stop_c) begin
                bus_err  <= in_frame && !at_boundary;
                in_frame <= 1'b0;
                rise_cnt <= '0;
            end else if (scl_rise && in_frame) begin
                rise_cnt <= (rise_cnt == CNT_W'(NEXT_ONE)) ? CNT_W'(2) : rise_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_unjam_ctrl.sv
module bus_unjam_ctrl
    import unjam_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int PH_W        = 8,
    parameter int MAX_PULSES  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             recover,
    input  logic [TMO_W-1:0] timeout_lim,
    input  logic [PH_W-1:0]  phase_len,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             busy,
    output logic             scl_stuck,
    output logic             sda_stuck,
    output logic [7:0]       status,
    output logic             bus_err
);
    localparam int NPW = $clog2(MAX_PULSES + 1);

    rec_state_t     state;
    logic [PH_W-1:0] ph_cnt;
    logic [NPW-1:0]  npulse;
    logic [1:0]      raw_lines, sync_lines, stuck_lines;
    logic            scl_s, sda_s, ph_done;

    assign raw_lines = {sda_in, scl_in};

    line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    assign scl_s = sync_lines[LINE_SCL];
    assign sda_s = sync_lines[LINE_SDA];

    for (genvar g = 0; g < 2; g++) begin : g_timer
        stuck_timer #(.CW(TMO_W)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (busy),
            .line_s (sync_lines[g]),
            .limit  (timeout_lim),
            .stuck  (stuck_lines[g])
        );
    end

    assign scl_stuck = stuck_lines[LINE_SCL];
    assign sda_stuck = stuck_lines[LINE_SDA];

    cond_detect #(.FRAME_RISES(9)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .mute    (busy),
        .bus_err (bus_err)
    );

    assign ph_done = ({1'b0, ph_cnt} + 1'b1) >= {1'b0, phase_len};

    // State register with phase timer, pulse counter and outcome code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            ph_cnt <= '0;
            npulse <= '0;
            status <= ST_NONE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    ph_cnt <= '0;
                    if (recover) begin
                        if (!scl_s) begin
                            status <= ST_SCL_STUCK;
                        end else begin
                            status <= ST_NONE;
                            npulse <= '0;
                            state  <= sda_s ? S_START_PREP : S_PULSE_LO;
                        end
                    end
                end
                S_PULSE_LO: begin
                    if (ph_done) begin
                        ph_cnt <= '0;
                        npulse <= npulse + 1'b1;
                        state  <= S_PULSE_HI;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                S_PULSE_HI: begin
                    if (ph_done) begin
                        ph_cnt <= '0;
                        if (sda_s) begin
                            state <= S_START_PREP;
                        end else if (npulse == NPW'(MAX_PULSES)) begin
                            status <= ST_SDA_FAIL;
                            state  <= S_IDLE;
                        end else begin
                            state <= S_PULSE_LO;
                        end
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                S_START_PREP: begin
                    if (!(sda_s && scl_s)) begin
                        ph_cnt <= '0;
                    end else if (ph_done) begin
                        ph_cnt <= '0;
                        state  <= S_START_HOLD;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                S_START_HOLD: begin
                    if (ph_done) begin
                        ph_cnt <= '0;
                        status <= ST_RESYNC_OK;
                        state  <= S_STOP_LO;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                S_STOP_LO: begin
                    if (ph_done) begin
                        ph_cnt <= '0;
                        state  <= S_STOP_HI;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                S_STOP_HI: begin
                    if (ph_done) begin
                        ph_cnt <= '0;
                        state  <= S_IDLE;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Wire drives decoded from the state
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        busy          = 1'b1;
        unique case (state)
            S_IDLE:       busy = 1'b0;
            S_PULSE_LO:   scl_drive_low = 1'b1;
            S_PULSE_HI:   ;
            S_START_PREP: ;
            S_START_HOLD: sda_drive_low = 1'b1;
            S_STOP_LO: begin
                scl_drive_low = 1'b1;
                sda_drive_low = 1'b1;
            end
            S_STOP_HI:    sda_drive_low = 1'b1;
            default:      busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_unjam_checker.sv
module bus_unjam_checker #(
    parameter int NPW        = 4,
    parameter int MAX_PULSES = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           recover,
    input logic           busy,
    input logic           scl_s,
    input logic           sda_s,
    input logic           scl_drive_low,
    input logic           sda_drive_low,
    input logic [NPW-1:0] npulse,
    input logic [7:0]     status,
    input logic           bus_err
);
    p_scl_low_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && recover && !scl_s) |=> !busy);

    p_pulse_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        npulse <= NPW'(MAX_PULSES));

    p_fail_is_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(status) && status == 8'hE0) |-> !busy);

    p_start_needs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drive_low) && !scl_drive_low) |-> ($past(sda_s) && $past(scl_s)));

    p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low));

    p_quiet_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !bus_err);
endmodule

bind bus_unjam_ctrl bus_unjam_checker #(.NPW(NPW), .MAX_PULSES(MAX_PULSES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .recover       (recover),
    .busy          (busy),
    .scl_s         (scl_s),
    .sda_s         (sda_s),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .npulse        (npulse),
    .status        (status),
    .bus_err       (bus_err)
);

// File: tb/bus_unjam_ctrl_test.sv
module bus_unjam_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recover = 1'b0;
    logic [15:0] timeout_lim = 16'd20;
    logic [7:0]  phase_len = 8'd4;
    logic        scl_drive_low, sda_drive_low, busy, scl_stuck, sda_stuck, bus_err;
    logic [7:0]  status;

    logic tb_scl_low = 1'b0;
    logic tb_sda_force = 1'b0;
    int   hold_falls = 0;
    logic scl_line, sda_line;

    int n_tests = 0, n_fail = 0;
    int scl_rises = 0, bus_starts = 0, bus_stops = 0, err_pulses = 0;
    int drove_in_window = 0;
    logic hold_window = 1'b0;
    logic done = 1'b0;

    assign scl_line = !(scl_drive_low || tb_scl_low);
    assign sda_line = !(sda_drive_low || tb_sda_force || (hold_falls != 0));

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_unjam_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .recover       (recover),
        .timeout_lim   (timeout_lim),
        .phase_len     (phase_len),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .busy          (busy),
        .scl_stuck     (scl_stuck),
        .sda_stuck     (sda_stuck),
        .status        (status),
        .bus_err       (bus_err)
    );

    // Slave model: keeps data low until it has seen hold_falls clock falls
    always @(negedge scl_line) if (hold_falls > 0) hold_falls = hold_falls - 1;
    always @(posedge scl_line) scl_rises++;
    always @(negedge sda_line) if (scl_line) bus_starts++;
    always @(posedge sda_line) if (scl_line) bus_stops++;
    always @(negedge clk) begin
        if (bus_err) err_pulses++;
        if (hold_window && sda_drive_low) drove_in_window++;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_recover();
        @(negedge clk);
        recover = 1'b1;
        @(negedge clk);
        recover = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic clear_counts();
        scl_rises = 0; bus_starts = 0; bus_stops = 0;
    endtask

    task automatic t_reset();
        check(status == 8'hF8, "R10 status", status, 8'hF8);
        check(!busy && !scl_drive_low && !sda_drive_low && !bus_err, "R10 outputs",
              {busy, scl_drive_low, sda_drive_low, bus_err}, 0);
    endtask

    task automatic t_scl_hang();
        tb_scl_low = 1'b1;
        cycles(15);
        check(!scl_stuck, "R1 scl not yet stuck", scl_stuck, 0);
        cycles(15);
        check(scl_stuck, "R1 scl stuck", scl_stuck, 1);
        clear_counts();
        pulse_recover();
        cycles(1);
        check(status == 8'hE8, "R2 scl stuck status", status, 8'hE8);
        cycles(10);
        check(!busy && !scl_drive_low && !sda_drive_low, "R2 no drive",
              {busy, scl_drive_low, sda_drive_low}, 0);
        tb_scl_low = 1'b0;
        cycles(5);
        check(!scl_stuck, "R1 scl flag clears", scl_stuck, 0);
    endtask

    task automatic t_sda_timeout();
        tb_sda_force = 1'b1;
        cycles(15);
        check(!sda_stuck, "R1 sda not yet stuck", sda_stuck, 0);
        cycles(15);
        check(sda_stuck, "R1 sda stuck", sda_stuck, 1);
        tb_sda_force = 1'b0;
        cycles(5);
        check(!sda_stuck, "R1 sda flag clears", sda_stuck, 0);
    endtask

    task automatic t_recover(input int k, input logic poke);
        int base_err;
        hold_falls = k;
        cycles(5);
        clear_counts();
        base_err = err_pulses;
        pulse_recover();
        if (poke) begin
            cycles(6);
            check(busy, "R7 busy during recovery", busy, 1);
            pulse_recover();
        end
        wait_idle();
        cycles(3);
        if (k <= 9) begin
            check(scl_rises == k + 1, "R3 pulse count", scl_rises, k + 1);
            check(bus_starts == 1 && bus_stops == 1, "R6 one START one STOP",
                  bus_starts * 10 + bus_stops, 11);
            check(status == 8'h08, "R6 resync status", status, 8'h08);
            check(scl_line && sda_line, "R6 lines released", {scl_line, sda_line}, 3);
        end else begin
            check(scl_rises == 9, "R4 nine pulses only", scl_rises, 9);
            check(bus_starts == 0, "R4 no START", bus_starts, 0);
            check(status == 8'hE0, "R4 fail status", status, 8'hE0);
            hold_falls = 0;
        end
        check(!busy && !scl_drive_low && !sda_drive_low, "R7 idle released",
              {busy, scl_drive_low, sda_drive_low}, 0);
        check(err_pulses == base_err, "R9 no error from recovery", err_pulses, base_err);
        cycles(5);
    endtask

    task automatic t_start_retry();
        phase_len = 8'd8;
        clear_counts();
        pulse_recover();
        cycles(2);
        tb_sda_force = 1'b1;
        hold_window = 1'b1;
        cycles(40);
        check(busy, "R5 waits while sda low", busy, 1);
        hold_window = 1'b0;
        tb_sda_force = 1'b0;
        check(drove_in_window == 0, "R5 no START while sda low", drove_in_window, 0);
        wait_idle();
        cycles(3);
        check(status == 8'h08, "R5 retried START succeeds", status, 8'h08);
        phase_len = 8'd4;
        cycles(5);
    endtask

    task automatic b_start();
        tb_sda_force = 1'b1; cycles(4);
        tb_scl_low = 1'b1; cycles(4);
    endtask

    task automatic b_bit(input logic b);
        tb_sda_force = !b; cycles(4);
        tb_scl_low = 1'b0; cycles(4);
        tb_scl_low = 1'b1; cycles(4);
    endtask

    task automatic b_stop();
        tb_sda_force = 1'b1; cycles(4);
        tb_scl_low = 1'b0; cycles(4);
        tb_sda_force = 1'b0; cycles(4);
    endtask

    task automatic b_rep_start();
        tb_sda_force = 1'b0; cycles(4);
        tb_scl_low = 1'b0; cycles(4);
        tb_sda_force = 1'b1; cycles(4);
        tb_scl_low = 1'b1; cycles(4);
    endtask

    task automatic t_bus_errors();
        int base;
        base = err_pulses;
        b_start();
        for (int i = 0; i < 9; i++) b_bit(i[0]);
        b_stop();
        cycles(4);
        check(err_pulses == base, "R8 legal byte no error", err_pulses, base);
        base = err_pulses;
        b_start();
        for (int i = 0; i < 3; i++) b_bit(1'b1);
        b_stop();
        cycles(4);
        check(err_pulses == base + 1, "R8 STOP mid byte", err_pulses, base + 1);
        base = err_pulses;
        b_start();
        for (int i = 0; i < 2; i++) b_bit(1'b0);
        b_rep_start();
        for (int i = 0; i < 9; i++) b_bit(1'b1);
        b_stop();
        cycles(4);
        check(err_pulses == base + 1, "R8 START mid byte", err_pulses, base + 1);
    endtask

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(3);
        t_reset();
        t_scl_hang();
        t_sda_timeout();
        t_recover(0, 1'b0);
        t_recover(3, 1'b0);
        t_recover(9, 1'b0);
        t_recover(10, 1'b0);
        t_recover(3, 1'b1);
        t_start_retry();
        t_bus_errors();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule